// File: doc/BRIEF.md
# Round-Robin Quantum Task Scheduler

This block decides, one time step at a time, which of a small fixed set of tasks owns the CPU. Before a run, software writes three things for each task slot: an enable bit, an arrival time and a burst length. The quantum length is held in a separate register. A start pulse resets the time-step counter to zero and begins the schedule. The block then moves forward on its own, one time step every `NUM_TASKS+3` clock cycles.

Inside each time step the sequence is fixed. First, the task slots whose arrival equals the current time are appended to a ready FIFO in ascending index order. Second, a task whose quantum has just run out is appended after them. Third, if the CPU is free, the task at the head of the FIFO is dispatched. Fourth, the running task executes for one unit.

Every time step produces a one-cycle tick that reports the step number and the task that ran, or an idle indication. When a task completes, the block reports its completion time, turnaround time and waiting time in the same cycle as the tick of its last step. When every enabled task has completed, `all_done` rises and the ticks stop.

Top module: `rr_quantum_sched`

## Requirements
- R1: A start pulse, accepted only while the block is not running, clears the step counter. Each time step then gives one `tick_valid` pulse, with `tick_time` counting 0, 1, 2 and so on. Consecutive ticks are exactly NUM_TASKS+3 clock cycles apart.
- R2: Ready tasks wait in a FIFO ordered by the time they became ready. When the CPU is free, the task at the head of the FIFO is dispatched.
- R3: A dispatched task runs for at most one quantum of consecutive steps. If it still has work left at the end of that quantum, it goes to the tail of the FIFO.
- R4: A task whose work ends before its quantum ends is not requeued. On the very next step the next task at the head of the FIFO is dispatched.
- R5: Tasks that arrive at the step where a quantum expires are queued ahead of the task that was preempted.
- R6: With the completion report, `fin_ctime` equals `tick_time`+1 of the task's last step. `fin_turnaround` equals `fin_ctime` minus the arrival time. `fin_waiting` equals the turnaround minus the burst length.
- R7: At a step where no task is queued or running, the tick shows `cpu_idle`=1 and `run_valid`=0.
- R8: The quantum is written through `q_we`/`q_value`. A written value of 0 behaves as a quantum of 1.
- R9: Tasks that arrive in the same step are queued in ascending slot index order.
- R10: Slots written with `reg_en`=0 are never scheduled and never reported. `all_done` rises once every enabled task has completed, and no tick follows it. With no enabled slot, `all_done` rises with no tick at all.
- R11: After reset, `tick_valid`, `run_valid`, `fin_valid` and `all_done` are 0 and `cpu_idle` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write the task slot selected by reg_idx |
| reg_idx | input | IDX_W | Task slot index |
| reg_en | input | 1 | Slot takes part in the schedule |
| reg_arrival | input | TIME_W | Arrival time step |
| reg_burst | input | TIME_W | Burst length in steps (nonzero) |
| q_we | input | 1 | Write the quantum register |
| q_value | input | QNT_W | Quantum length, 0 treated as 1 |
| start | input | 1 | Begin a schedule from step 0 |
| tick_valid | output | 1 | One-cycle pulse per time step |
| tick_time | output | TIME_W | Step number of the current tick |
| run_valid | output | 1 | A task ran during this step |
| run_id | output | IDX_W | Slot of the task that ran |
| cpu_idle | output | 1 | No task ran during this step |
| fin_valid | output | 1 | A task completed in this step |
| fin_id | output | IDX_W | Slot of the completed task |
| fin_ctime | output | TIME_W | Completion time |
| fin_turnaround | output | TIME_W | Completion minus arrival |
| fin_waiting | output | TIME_W | Turnaround minus burst |
| all_done | output | 1 | Every enabled task has completed |

## Verification
Some properties are checked on every cycle. Ticks are single pulses. An idle tick never carries a task identifier. A completion report always comes with a tick that names the same task and has a completion time one step past it. Waiting time never exceeds turnaround, and no tick follows `all_done`. The bench scenarios show what those local checks cannot: the actual dispatch order, with quantum preemption, requeue after newly arrived tasks, same-step arrival ordering and idle steps before the first arrival. They also check the exact completion statistics and the tick spacing in clock cycles.

// File: rtl/rr_pkg.sv
package rr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_REQ,
    ST_DISP,
    ST_EXEC,
    ST_DONE
  } sched_state_t;
endpackage

// File: rtl/rr_fifo.sv
module rr_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign head  = mem[rd_ptr];
  assign empty = (count == '0);
endmodule

// File: rtl/rr_stats.sv
module rr_stats #(
  parameter int IDX_W  = 2,
  parameter int TIME_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev,
  input  logic [IDX_W-1:0]  ev_id,
  input  logic [TIME_W-1:0] ev_ctime,
  input  logic [TIME_W-1:0] ev_arrival,
  input  logic [TIME_W-1:0] ev_burst,
  output logic              fin_valid,
  output logic [IDX_W-1:0]  fin_id,
  output logic [TIME_W-1:0] fin_ctime,
  output logic [TIME_W-1:0] fin_turnaround,
  output logic [TIME_W-1:0] fin_waiting
);
  logic [TIME_W-1:0] tat;
  assign tat = ev_ctime - ev_arrival;

  always_ff @(posedge clk) begin
    if (rst) begin
      fin_valid      <= 1'b0;
      fin_id         <= '0;
      fin_ctime      <= '0;
      fin_turnaround <= '0;
      fin_waiting    <= '0;
    end else begin
      fin_valid <= ev;
      if (ev) begin
        fin_id         <= ev_id;
        fin_ctime      <= ev_ctime;
        fin_turnaround <= tat;
        fin_waiting    <= tat - ev_burst;
      end
    end
  end
endmodule

// File: rtl/rr_quantum_sched.sv
module rr_quantum_sched #(
  parameter int NUM_TASKS = 4,
  parameter int TIME_W    = 8,
  parameter int QNT_W     = 4,
  localparam int IDX_W    = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic              reg_en,
  input  logic [TIME_W-1:0] reg_arrival,
  input  logic [TIME_W-1:0] reg_burst,
  input  logic              q_we,
  input  logic [QNT_W-1:0]  q_value,
  input  logic              start,
  output logic              tick_valid,
  output logic [TIME_W-1:0] tick_time,
  output logic              run_valid,
  output logic [IDX_W-1:0]  run_id,
  output logic              cpu_idle,
  output logic              fin_valid,
  output logic [IDX_W-1:0]  fin_id,
  output logic [TIME_W-1:0] fin_ctime,
  output logic [TIME_W-1:0] fin_turnaround,
  output logic [TIME_W-1:0] fin_waiting,
  output logic              all_done
);
  import rr_pkg::*;
  localparam int CNT_W = $clog2(NUM_TASKS + 1);

  sched_state_t      state;
  logic [TIME_W-1:0] arr_q   [NUM_TASKS];
  logic [TIME_W-1:0] burst_q [NUM_TASKS];
  logic [TIME_W-1:0] rem_q   [NUM_TASKS];
  logic [NUM_TASKS-1:0] en_q;
  logic [QNT_W-1:0]  quantum;
  logic [QNT_W:0]    eff_q;
  logic [QNT_W-1:0]  slice;
  logic [TIME_W-1:0] now_t;
  logic [IDX_W-1:0]  scan_idx, cur;
  logic              cur_valid, pend;
  logic [CNT_W-1:0]  left, en_count;
  logic              launch, fifo_push, fifo_pop, fifo_empty, fin_ev;
  logic [IDX_W-1:0]  fifo_din, fifo_head;

  assign launch = start && (state == ST_IDLE || state == ST_DONE);
  assign eff_q  = (quantum == '0) ? (QNT_W+1)'(1) : {1'b0, quantum};

  always_comb begin
    en_count = '0;
    for (int i = 0; i < NUM_TASKS; i++) en_count = en_count + CNT_W'(en_q[i]);
  end

  // Task table: written by the registration port
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else if (reg_we) begin
      en_q[reg_idx]    <= reg_en;
      arr_q[reg_idx]   <= reg_arrival;
      burst_q[reg_idx] <= reg_burst;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       quantum <= QNT_W'(1);
    else if (q_we) quantum <= q_value;
  end

  // Remaining work per slot
  always_ff @(posedge clk) begin
    if (launch) begin
      for (int i = 0; i < NUM_TASKS; i++) rem_q[i] <= burst_q[i];
    end else if (state == ST_EXEC && cur_valid) begin
      rem_q[cur] <= rem_q[cur] - 1'b1;
    end
  end

  assign fifo_push = (state == ST_SCAN && en_q[scan_idx] && arr_q[scan_idx] == now_t) ||
                     (state == ST_REQ && pend);
  assign fifo_din  = (state == ST_REQ) ? cur : scan_idx;
  assign fifo_pop  = (state == ST_DISP) && (left != '0) && !cur_valid && !fifo_empty;
  assign fin_ev    = (state == ST_EXEC) && cur_valid && (rem_q[cur] == TIME_W'(1));

  rr_fifo #(.DEPTH(NUM_TASKS), .W(IDX_W)) u_ready (
    .clk(clk), .rst(rst), .flush(launch),
    .push(fifo_push), .push_data(fifo_din),
    .pop(fifo_pop), .head(fifo_head), .empty(fifo_empty)
  );

  rr_stats #(.IDX_W(IDX_W), .TIME_W(TIME_W)) u_stats (
    .clk(clk), .rst(rst), .ev(fin_ev), .ev_id(cur),
    .ev_ctime(now_t + 1'b1), .ev_arrival(arr_q[cur]), .ev_burst(burst_q[cur]),
    .fin_valid(fin_valid), .fin_id(fin_id), .fin_ctime(fin_ctime),
    .fin_turnaround(fin_turnaround), .fin_waiting(fin_waiting)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      now_t      <= '0;
      scan_idx   <= '0;
      cur        <= '0;
      cur_valid  <= 1'b0;
      pend       <= 1'b0;
      slice      <= '0;
      left       <= '0;
      tick_valid <= 1'b0;
      tick_time  <= '0;
      run_valid  <= 1'b0;
      run_id     <= '0;
      cpu_idle   <= 1'b1;
      all_done   <= 1'b0;
    end else begin
      tick_valid <= 1'b0;
      case (state)
        ST_IDLE, ST_DONE: if (launch) begin
          now_t     <= '0;
          scan_idx  <= '0;
          cur_valid <= 1'b0;
          pend      <= 1'b0;
          left      <= en_count;
          all_done  <= 1'b0;
          state     <= ST_SCAN;
        end
        ST_SCAN: begin
          scan_idx <= scan_idx + 1'b1;
          if (scan_idx == IDX_W'(NUM_TASKS - 1)) state <= ST_REQ;
        end
        ST_REQ: begin
          if (pend) begin
            cur_valid <= 1'b0;
            pend      <= 1'b0;
          end
          state <= ST_DISP;
        end
        ST_DISP: begin
          if (left == '0) begin
            all_done  <= 1'b1;
            cpu_idle  <= 1'b1;
            run_valid <= 1'b0;
            state     <= ST_DONE;
          end else begin
            if (fifo_pop) begin
              cur       <= fifo_head;
              cur_valid <= 1'b1;
              slice     <= '0;
            end
            state <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          tick_valid <= 1'b1;
          tick_time  <= now_t;
          run_valid  <= cur_valid;
          run_id     <= cur;
          cpu_idle   <= !cur_valid;
          if (cur_valid) begin
            slice <= slice + 1'b1;
            if (rem_q[cur] == TIME_W'(1)) begin
              cur_valid <= 1'b0;
              left      <= left - 1'b1;
            end else if (({1'b0, slice} + 1'b1) >= eff_q) begin
              pend <= 1'b1;
            end
          end
          now_t    <= now_t + 1'b1;
          scan_idx <= '0;
          state    <= ST_SCAN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rr_quantum_sched_chk.sv
module rr_quantum_sched_chk #(
  parameter int IDX_W  = 2,
  parameter int TIME_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_valid,
  input logic [TIME_W-1:0] tick_time,
  input logic              run_valid,
  input logic [IDX_W-1:0]  run_id,
  input logic              cpu_idle,
  input logic              fin_valid,
  input logic [IDX_W-1:0]  fin_id,
  input logic [TIME_W-1:0] fin_ctime,
  input logic [TIME_W-1:0] fin_turnaround,
  input logic [TIME_W-1:0] fin_waiting,
  input logic              all_done
);
  AST_TICK_PULSE: assert property (@(posedge clk) disable iff (rst)
    tick_valid |=> !tick_valid); // R1

  AST_IDLE_NO_ID: assert property (@(posedge clk) disable iff (rst)
    (tick_valid && cpu_idle) |-> !run_valid); // R7

  AST_FIN_MATCH_RUN: assert property (@(posedge clk) disable iff (rst)
    fin_valid |-> (tick_valid && run_valid && run_id == fin_id)); // R4

  AST_FIN_CTIME: assert property (@(posedge clk) disable iff (rst)
    fin_valid |-> (fin_ctime == TIME_W'(tick_time + 1'b1))); // R6

  AST_WAIT_LE_TAT: assert property (@(posedge clk) disable iff (rst)
    fin_valid |-> (fin_waiting <= fin_turnaround)); // R6

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    all_done |-> !tick_valid); // R10
endmodule

bind rr_quantum_sched rr_quantum_sched_chk #(.IDX_W(IDX_W), .TIME_W(TIME_W)) u_chk (
  .clk(clk), .rst(rst), .tick_valid(tick_valid), .tick_time(tick_time),
  .run_valid(run_valid), .run_id(run_id), .cpu_idle(cpu_idle),
  .fin_valid(fin_valid), .fin_id(fin_id), .fin_ctime(fin_ctime),
  .fin_turnaround(fin_turnaround), .fin_waiting(fin_waiting), .all_done(all_done)
);

// File: tb/rr_quantum_sched_test.sv
module rr_quantum_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;
  localparam int TW = 8;
  localparam int QW = 4;
  localparam int IDLE_CODE = 15;

  // {scenario, tick_time, expected run slot or IDLE_CODE}
  localparam int NVEC = 23;
  localparam int VEC [NVEC][3] = '{
    '{0,0,0}, '{0,1,0}, '{0,2,0}, '{0,3,2}, '{0,4,2}, '{0,5,2},
    '{0,6,0}, '{0,7,0}, '{0,8,0}, '{0,9,1}, '{0,10,1}, '{0,11,2},
    '{0,12,2}, '{0,13,2}, '{0,14,0}, '{0,15,0}, '{0,16,2},
    '{1,0,15}, '{1,1,15}, '{1,2,0}, '{1,3,1}, '{1,4,2}, '{1,5,0}
  };
  // {scenario, slot, completion, turnaround, waiting}
  localparam int NST = 6;
  localparam int STV [NST][5] = '{
    '{0,0,16,16,8}, '{0,1,11,7,5}, '{0,2,17,16,9},
    '{1,0,6,4,2},   '{1,1,4,1,0},  '{1,2,5,2,1}
  };

  logic clk = 0, rst = 1;
  logic reg_we = 0, reg_en = 0, q_we = 0, start = 0;
  logic [1:0] reg_idx = '0;
  logic [TW-1:0] reg_arrival = '0, reg_burst = '0;
  logic [QW-1:0] q_value = '0;
  logic tick_valid, run_valid, cpu_idle, fin_valid, all_done;
  logic [TW-1:0] tick_time, fin_ctime, fin_turnaround, fin_waiting;
  logic [1:0] run_id, fin_id;

  int checks = 0, fails = 0, cyc = 0, scn = 0;
  int cap_run [3][32];
  int cap_fin [3][NT][3];
  int ticks [3];
  int tick_cyc [2];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rr_quantum_sched #(.NUM_TASKS(NT), .TIME_W(TW), .QNT_W(QW)) uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_idx(reg_idx), .reg_en(reg_en),
    .reg_arrival(reg_arrival), .reg_burst(reg_burst), .q_we(q_we), .q_value(q_value),
    .start(start), .tick_valid(tick_valid), .tick_time(tick_time),
    .run_valid(run_valid), .run_id(run_id), .cpu_idle(cpu_idle),
    .fin_valid(fin_valid), .fin_id(fin_id), .fin_ctime(fin_ctime),
    .fin_turnaround(fin_turnaround), .fin_waiting(fin_waiting), .all_done(all_done)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor samples registered outputs at the falling edge
  always @(negedge clk) begin
    if (!rst && tick_valid) begin
      if (ticks[scn] < 2 && scn == 0) tick_cyc[ticks[scn]] = cyc;
      ticks[scn]++;
      if (tick_time < 32)
        cap_run[scn][tick_time] = run_valid ? int'(run_id) : (cpu_idle ? IDLE_CODE : 99);
    end
    if (!rst && fin_valid) begin
      cap_fin[scn][fin_id][0] = fin_ctime;
      cap_fin[scn][fin_id][1] = fin_turnaround;
      cap_fin[scn][fin_id][2] = fin_waiting;
    end
  end

  task automatic set_task(input int idx, input bit en, input int arr, input int bst);
    @(negedge clk);
    reg_we = 1; reg_idx = 2'(idx); reg_en = en;
    reg_arrival = TW'(arr); reg_burst = TW'(bst);
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic set_q(input int v);
    @(negedge clk);
    q_we = 1; q_value = QW'(v);
    @(negedge clk);
    q_we = 0;
  endtask

  task automatic run_scn(input int s, input string req);
    int n;
    @(negedge clk);
    scn = s;
    start = 1;
    @(negedge clk);
    start = 0;
    n = 0;
    while (!all_done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(req, int'(all_done), 1);
  endtask

  initial begin
    for (int s = 0; s < 3; s++) begin
      ticks[s] = 0;
      for (int t = 0; t < 32; t++) cap_run[s][t] = -1;
      for (int k = 0; k < NT; k++)
        for (int f = 0; f < 3; f++) cap_fin[s][k][f] = -1;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11: reset state
    check("R11 tick_valid", int'(tick_valid), 0);
    check("R11 run_valid", int'(run_valid), 0);
    check("R11 fin_valid", int'(fin_valid), 0);
    check("R11 all_done", int'(all_done), 0);
    check("R11 cpu_idle", int'(cpu_idle), 1);

    // Scenario 0: quantum 3, preemption and requeue (R2, R3, R4)
    set_q(3);
    set_task(0, 1, 0, 8);
    set_task(1, 1, 4, 2);
    set_task(2, 1, 1, 7);
    set_task(3, 0, 0, 1);
    run_scn(0, "R10 done scenario 0");

    // Scenario 1: quantum 0 acts as 1 (R8); idle steps (R7);
    // same-step arrivals ascending (R9) ahead of preempted task (R5)
    set_q(0);
    set_task(0, 1, 2, 2);
    set_task(1, 1, 3, 1);
    set_task(2, 1, 3, 1);
    run_scn(1, "R10 done scenario 1");

    // Scenario 2: nothing enabled (R10)
    for (int k = 0; k < NT; k++) set_task(k, 0, 0, 1);
    run_scn(2, "R10 done scenario 2");

    // Dispatch order per step: R2 R3 R4 R5 R7 R8 R9
    for (int v = 0; v < NVEC; v++)
      check($sformatf("R3 R5 R9 order s%0d t%0d", VEC[v][0], VEC[v][1]),
            cap_run[VEC[v][0]][VEC[v][1]], VEC[v][2]);
    for (int v = 0; v < NST; v++) begin
      check($sformatf("R6 ctime s%0d id%0d", STV[v][0], STV[v][1]),
            cap_fin[STV[v][0]][STV[v][1]][0], STV[v][2]);
      check($sformatf("R6 turnaround s%0d id%0d", STV[v][0], STV[v][1]),
            cap_fin[STV[v][0]][STV[v][1]][1], STV[v][3]);
      check($sformatf("R6 waiting s%0d id%0d", STV[v][0], STV[v][1]),
            cap_fin[STV[v][0]][STV[v][1]][2], STV[v][4]);
    end
    check("R10 tick count s0", ticks[0], 17);
    check("R10 tick count s1", ticks[1], 6);
    check("R10 tick count s2", ticks[2], 0);
    check("R10 disabled slot unreported", cap_fin[0][3][0], -1);
    check("R1 tick spacing", tick_cyc[1] - tick_cyc[0], NT + 3);
    check("R1 first step number", cap_run[0][0], 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule